// File: doc/BRIEF.md
# Display Geometry Sanitiser and Scan-out Base Calculator

This block takes a requested display geometry and cleans it up. The request holds horizontal and vertical resolution, colour depth, virtual line width, horizontal and vertical pan offsets, and the size of the frame memory in bytes. The block forces every value into its legal range and works out the line pitch in bytes. It then computes the byte address where scan-out begins. If the requested pan would read past the end of frame memory, the block first drops the vertical pan and then, if needed, the horizontal pan as well. The corrected values come back with the result, so the register file can write them back in place of the requested ones.

Requests arrive on a valid/ready stream and results leave on another. A request is taken on a cycle where `req_valid` and `req_ready` are both high. The block accepts a new request only when it is idle, or in the same cycle that its current result is taken. Once `res_valid` rises, it stays high and every result field holds its value until `res_ready` is seen high at a clock edge. Two products are needed: vertical pan times pitch and vertical resolution times pitch. Both come from shift-add multipliers that run in parallel, one multiplier bit per cycle.

Top module: `geom_clamp_unit`

## Requirements
- R1: The returned horizontal resolution is the request with its low three bits cleared. If that leaves 0, the result is 8.
- R2: A vertical resolution of 0 is returned as 1. A vertical resolution above 1600 is returned as 1600.
- R3: The virtual width is first limited to at most 1920. It is then raised to the returned horizontal resolution if it is below that. Because the floor is applied last, a horizontal resolution above 1920 wins over the 1920 ceiling.
- R4: The horizontal pan is limited to at most 1920. The vertical pan is limited to at most 1600. Both limits apply before the memory-fit step.
- R5: At depth 4 (planar), the pitch is the virtual width divided by 8, rounded down. The start address is the vertical pan times the pitch, plus the horizontal pan divided by 8.
- R6: At depths 8, 15, 16, 24 and 32, the bytes per pixel are the depth divided by 8, rounded down: 1, 1, 2, 3 and 4 bytes. The pitch is the virtual width times the bytes per pixel. The start address is the vertical pan times the pitch, plus the horizontal pan times the bytes per pixel.
- R7: Any other depth value uses 1 byte per pixel, the same as depth 8.
- R8: The displayed span is the vertical resolution times the pitch. If the start address plus the span exceeds the memory size, the vertical pan is returned as 0 and the start address is recomputed from the horizontal pan alone.
- R9: If the recomputed start address plus the span still exceeds the memory size, the horizontal pan and the start address are both returned as 0.
- R10: After reset `res_valid` is low and `req_ready` is high. While `res_valid` is high and `res_ready` is low, the result stays valid and every result field holds its value.
- R11: `req_ready` is high only when the block is idle, or when a result is being taken in that cycle. A request offered in the same cycle a result is taken is accepted, and it produces the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request stream valid |
| req_ready | output | 1 | Request stream ready |
| req_xres | input | 16 | Requested horizontal resolution |
| req_yres | input | 16 | Requested vertical resolution |
| req_bpp | input | 16 | Requested colour depth in bits |
| req_vwidth | input | 16 | Requested virtual line width in pixels |
| req_xoff | input | 16 | Requested horizontal pan in pixels |
| req_yoff | input | 16 | Requested vertical pan in lines |
| req_mem_bytes | input | 26 | Frame memory size in bytes |
| res_valid | output | 1 | Result stream valid |
| res_ready | input | 1 | Result stream ready |
| res_xres | output | 16 | Sanitised horizontal resolution |
| res_yres | output | 16 | Sanitised vertical resolution |
| res_vwidth | output | 16 | Sanitised virtual width |
| res_xoff | output | 16 | Sanitised horizontal pan |
| res_yoff | output | 16 | Sanitised vertical pan |
| res_pitch | output | 19 | Line pitch in bytes |
| res_start | output | 31 | Scan-out start byte address |

## Verification
Two stream events can fall in the same cycle: a finished result is taken, and a new request is accepted. The bench keeps the next request waiting on the input with `req_valid` high. It lets the result be taken either at once or through a stuttering `res_ready`. The bench records that at least one accept happened in the very cycle a result left. It then checks that every result still matches, in order, the model value queued for its request. Holding is judged by sampling the fields in every stalled cycle and comparing them with the cycle before.

// File: rtl/geom_pkg.sv
package geom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_MUL,
    ST_DONE
  } geom_state_e;

  // Bytes per pixel for packed depths; unknown depths fall back to one byte.
  function automatic logic [2:0] px_bytes(input logic [15:0] depth);
    case (depth)
      16'd16:  px_bytes = 3'd2;
      16'd24:  px_bytes = 3'd3;
      16'd32:  px_bytes = 3'd4;
      default: px_bytes = 3'd1;
    endcase
  endfunction

endpackage

// File: rtl/geom_clamp.sv
module geom_clamp #(
  parameter int DW   = 16,
  parameter int PW   = 19,
  parameter int MAXX = 1920,
  parameter int MAXY = 1600
) (
  input  logic [DW-1:0] xres,
  input  logic [DW-1:0] yres,
  input  logic [DW-1:0] bpp,
  input  logic [DW-1:0] vwidth,
  input  logic [DW-1:0] xoff,
  input  logic [DW-1:0] yoff,
  output logic [DW-1:0] c_xres,
  output logic [DW-1:0] c_yres,
  output logic [DW-1:0] c_vwidth,
  output logic [DW-1:0] c_xoff,
  output logic [DW-1:0] c_yoff,
  output logic [PW-1:0] pitch,
  output logic [PW-1:0] xbytes
);
  import geom_pkg::*;

  localparam logic [DW-1:0] LIM_X = DW'(MAXX);
  localparam logic [DW-1:0] LIM_Y = DW'(MAXY);

  logic [DW-1:0] x_masked;
  logic [DW-1:0] vw_cap;
  logic [2:0]    bytes;
  logic          planar;

  always_comb begin
    x_masked = {xres[DW-1:3], 3'b000};
    c_xres   = (x_masked == '0) ? DW'(8) : x_masked;

    vw_cap   = (vwidth > LIM_X) ? LIM_X : vwidth;
    c_vwidth = (vw_cap < c_xres) ? c_xres : vw_cap;

    c_xoff   = (xoff > LIM_X) ? LIM_X : xoff;
    c_yoff   = (yoff > LIM_Y) ? LIM_Y : yoff;

    if (yres == '0)        c_yres = DW'(1);
    else if (yres > LIM_Y) c_yres = LIM_Y;
    else                   c_yres = yres;

    planar = (bpp == DW'(4));
    bytes  = px_bytes(bpp);
    if (planar) begin
      pitch  = PW'(c_vwidth >> 3);
      xbytes = PW'(c_xoff >> 3);
    end else begin
      pitch  = PW'(c_vwidth) * PW'(bytes);
      xbytes = PW'(c_xoff) * PW'(bytes);
    end
  end

endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
  parameter int AW = 19,
  parameter int BW = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [AW-1:0]    a,
  input  logic [BW-1:0]    b,
  output logic [AW+BW-1:0] p,
  output logic             done
);
  localparam int RW = AW + BW;
  localparam int CW = $clog2(BW + 1);

  logic [RW-1:0] acc;
  logic [RW-1:0] mcand;
  logic [BW-1:0] mplier;
  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc    <= '0;
      mcand  <= '0;
      mplier <= '0;
      cnt    <= '0;
      run    <= 1'b0;
      done   <= 1'b0;
    end else if (start) begin
      acc    <= '0;
      mcand  <= RW'(a);
      mplier <= b;
      cnt    <= CW'(BW);
      run    <= 1'b1;
      done   <= 1'b0;
    end else if (run) begin
      if (mplier[0]) acc <= acc + mcand;
      mcand  <= mcand << 1;
      mplier <= mplier >> 1;
      cnt    <= cnt - 1'b1;
      if (cnt == CW'(1)) begin
        run  <= 1'b0;
        done <= 1'b1;
      end
    end else begin
      done <= 1'b0;
    end
  end

  assign p = acc;

endmodule

// File: rtl/geom_fit.sv
module geom_fit #(
  parameter int DW   = 16,
  parameter int PW   = 19,
  parameter int PRW  = 30,
  parameter int MEMW = 26
) (
  input  logic [PRW-1:0]  prod_pan,
  input  logic [PRW-1:0]  span,
  input  logic [PW-1:0]   xbytes,
  input  logic [MEMW-1:0] mem_bytes,
  input  logic [DW-1:0]   xoff_in,
  input  logic [DW-1:0]   yoff_in,
  output logic [DW-1:0]   xoff_out,
  output logic [DW-1:0]   yoff_out,
  output logic [PRW:0]    start_out
);
  localparam int FW = (PRW + 2 > MEMW + 1) ? PRW + 2 : MEMW + 1;

  logic [FW-1:0] first_try;
  logic [FW-1:0] second_try;
  logic [FW-1:0] span_w;
  logic [FW-1:0] mem_w;
  logic          miss1;
  logic          miss2;

  always_comb begin
    first_try  = FW'(prod_pan) + FW'(xbytes);
    second_try = FW'(xbytes);
    span_w     = FW'(span);
    mem_w      = FW'(mem_bytes);
    miss1      = (first_try + span_w) > mem_w;
    miss2      = (second_try + span_w) > mem_w;

    xoff_out  = xoff_in;
    yoff_out  = yoff_in;
    start_out = (PRW + 1)'(first_try);
    if (miss1) begin
      yoff_out  = '0;
      start_out = (PRW + 1)'(second_try);
      if (miss2) begin
        xoff_out  = '0;
        start_out = '0;
      end
    end
  end

endmodule

// File: rtl/geom_clamp_unit.sv
module geom_clamp_unit #(
  parameter int DW   = 16,
  parameter int MEMW = 26,
  parameter int MAXX = 1920,
  parameter int MAXY = 1600,
  localparam int PW  = DW + 3,
  localparam int MB  = $clog2(MAXY + 1),
  localparam int PRW = PW + MB
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_xres,
  input  logic [DW-1:0]   req_yres,
  input  logic [DW-1:0]   req_bpp,
  input  logic [DW-1:0]   req_vwidth,
  input  logic [DW-1:0]   req_xoff,
  input  logic [DW-1:0]   req_yoff,
  input  logic [MEMW-1:0] req_mem_bytes,
  output logic            res_valid,
  input  logic            res_ready,
  output logic [DW-1:0]   res_xres,
  output logic [DW-1:0]   res_yres,
  output logic [DW-1:0]   res_vwidth,
  output logic [DW-1:0]   res_xoff,
  output logic [DW-1:0]   res_yoff,
  output logic [PW-1:0]   res_pitch,
  output logic [PRW:0]    res_start
);
  import geom_pkg::*;

  geom_state_e state;

  logic [DW-1:0]   n_xres, n_yres, n_vw, n_xoff, n_yoff;
  logic [PW-1:0]   n_pitch, n_xbytes;

  logic [DW-1:0]   q_xres, q_yres, q_vw, q_xoff, q_yoff;
  logic [PW-1:0]   q_pitch, q_xbytes;
  logic [MEMW-1:0] mem_q;

  logic [PRW-1:0]  prod_pan, prod_span;
  logic            done_pan, done_span;
  logic            mul_start;

  logic [DW-1:0]   f_xoff, f_yoff;
  logic [PRW:0]    f_start;
  logic [DW-1:0]   o_xoff, o_yoff;
  logic [PRW:0]    o_start;

  logic            accept;

  geom_clamp #(.DW(DW), .PW(PW), .MAXX(MAXX), .MAXY(MAXY)) u_clamp (
    .xres     (req_xres),
    .yres     (req_yres),
    .bpp      (req_bpp),
    .vwidth   (req_vwidth),
    .xoff     (req_xoff),
    .yoff     (req_yoff),
    .c_xres   (n_xres),
    .c_yres   (n_yres),
    .c_vwidth (n_vw),
    .c_xoff   (n_xoff),
    .c_yoff   (n_yoff),
    .pitch    (n_pitch),
    .xbytes   (n_xbytes)
  );

  seq_mult #(.AW(PW), .BW(MB)) u_mul_pan (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_start),
    .a     (q_pitch),
    .b     (MB'(q_yoff)),
    .p     (prod_pan),
    .done  (done_pan)
  );

  seq_mult #(.AW(PW), .BW(MB)) u_mul_span (
    .clk   (clk),
    .rst_n (rst_n),
    .start (mul_start),
    .a     (q_pitch),
    .b     (MB'(q_yres)),
    .p     (prod_span),
    .done  (done_span)
  );

  geom_fit #(.DW(DW), .PW(PW), .PRW(PRW), .MEMW(MEMW)) u_fit (
    .prod_pan  (prod_pan),
    .span      (prod_span),
    .xbytes    (q_xbytes),
    .mem_bytes (mem_q),
    .xoff_in   (q_xoff),
    .yoff_in   (q_yoff),
    .xoff_out  (f_xoff),
    .yoff_out  (f_yoff),
    .start_out (f_start)
  );

  always_comb begin
    req_ready = (state == ST_IDLE) || ((state == ST_DONE) && res_ready);
    res_valid = (state == ST_DONE);
    mul_start = (state == ST_LOAD);
    accept    = req_valid && req_ready;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      q_xres   <= '0;
      q_yres   <= '0;
      q_vw     <= '0;
      q_xoff   <= '0;
      q_yoff   <= '0;
      q_pitch  <= '0;
      q_xbytes <= '0;
      mem_q    <= '0;
      o_xoff   <= '0;
      o_yoff   <= '0;
      o_start  <= '0;
    end else begin
      if (accept) begin
        q_xres   <= n_xres;
        q_yres   <= n_yres;
        q_vw     <= n_vw;
        q_xoff   <= n_xoff;
        q_yoff   <= n_yoff;
        q_pitch  <= n_pitch;
        q_xbytes <= n_xbytes;
        mem_q    <= req_mem_bytes;
      end
      case (state)
        ST_IDLE: if (accept) state <= ST_LOAD;
        ST_LOAD: state <= ST_MUL;
        ST_MUL: begin
          if (done_pan && done_span) begin
            o_xoff  <= f_xoff;
            o_yoff  <= f_yoff;
            o_start <= f_start;
            state   <= ST_DONE;
          end
        end
        ST_DONE: begin
          if (res_ready) state <= accept ? ST_LOAD : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign res_xres   = q_xres;
  assign res_yres   = q_yres;
  assign res_vwidth = q_vw;
  assign res_pitch  = q_pitch;
  assign res_xoff   = o_xoff;
  assign res_yoff   = o_yoff;
  assign res_start  = o_start;

endmodule

// File: rtl/geom_clamp_chk.sv
module geom_clamp_chk #(
  parameter int DW   = 16,
  parameter int MEMW = 26,
  parameter int MAXX = 1920,
  parameter int MAXY = 1600,
  parameter int PW   = 19,
  parameter int PRW  = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            res_valid,
  input logic            res_ready,
  input logic [DW-1:0]   res_xres,
  input logic [DW-1:0]   res_yres,
  input logic [DW-1:0]   res_vwidth,
  input logic [DW-1:0]   res_xoff,
  input logic [DW-1:0]   res_yoff,
  input logic [PW-1:0]   res_pitch,
  input logic [PRW:0]    res_start,
  input logic [MEMW-1:0] mem_q
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_start) && $stable(res_pitch)
                                   && $stable(res_xoff) && $stable(res_yoff)));

  // R1
  xres_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_xres[2:0] == 3'b000) && (res_xres != '0)));

  // R2
  yres_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_yres != '0) && (res_yres <= DW'(MAXY))));

  // R3
  vwidth_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_vwidth >= res_xres));

  // R4
  offset_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ((res_xoff <= DW'(MAXX)) && (res_yoff <= DW'(MAXY))));

  // R8
  fit_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_xoff != '0)) |->
      ((64'(res_start) + 64'(res_yres) * 64'(res_pitch)) <= 64'(mem_q)));

  // R11
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!res_valid || res_ready));

  // R11
  accept_leaves_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !res_valid);

endmodule

bind geom_clamp_unit geom_clamp_chk #(
  .DW(DW), .MEMW(MEMW), .MAXX(MAXX), .MAXY(MAXY), .PW(PW), .PRW(PRW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .res_valid  (res_valid),
  .res_ready  (res_ready),
  .res_xres   (res_xres),
  .res_yres   (res_yres),
  .res_vwidth (res_vwidth),
  .res_xoff   (res_xoff),
  .res_yoff   (res_yoff),
  .res_pitch  (res_pitch),
  .res_start  (res_start),
  .mem_q      (mem_q)
);

// File: tb/tb_geom_clamp_unit.sv
module tb_geom_clamp_unit;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    longint xres, yres, vw, xoff, yoff, pitch, start;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_xres = '0, req_yres = '0, req_bpp = '0;
  logic [15:0] req_vwidth = '0, req_xoff = '0, req_yoff = '0;
  logic [25:0] req_mem_bytes = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [15:0] res_xres, res_yres, res_vwidth, res_xoff, res_yoff;
  logic [18:0] res_pitch;
  logic [30:0] res_start;

  int   checks = 0;
  int   errors = 0;
  int   cyc = 0;
  bit   bp_on = 1'b0;
  bit   overlap_seen = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  geom_clamp_unit dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_xres(req_xres), .req_yres(req_yres), .req_bpp(req_bpp),
    .req_vwidth(req_vwidth), .req_xoff(req_xoff), .req_yoff(req_yoff),
    .req_mem_bytes(req_mem_bytes),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_xres(res_xres), .res_yres(res_yres), .res_vwidth(res_vwidth),
    .res_xoff(res_xoff), .res_yoff(res_yoff),
    .res_pitch(res_pitch), .res_start(res_start)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic exp_t model(input longint xr, input longint yr, input longint bp,
                                 input longint vw, input longint xo, input longint yo,
                                 input longint mem);
    exp_t   e;
    longint nb, xb, st;
    xr = xr - (xr % 8);
    if (xr == 0) xr = 8;
    if (vw > 1920) vw = 1920;
    if (vw < xr) vw = xr;
    if (xo > 1920) xo = 1920;
    if (yo > 1600) yo = 1600;
    if (yr == 0) yr = 1;
    if (yr > 1600) yr = 1600;
    case (bp)
      16: nb = 2;
      24: nb = 3;
      32: nb = 4;
      default: nb = 1;
    endcase
    if (bp == 4) begin
      e.pitch = vw / 8;
      xb = xo / 8;
    end else begin
      e.pitch = vw * nb;
      xb = xo * nb;
    end
    st = yo * e.pitch + xb;
    if (st + yr * e.pitch > mem) begin
      yo = 0;
      st = xb;
      if (st + yr * e.pitch > mem) begin
        xo = 0;
        st = 0;
      end
    end
    e.xres = xr; e.yres = yr; e.vw = vw; e.xoff = xo; e.yoff = yo; e.start = st;
    return e;
  endfunction

  task automatic send(input int xr, input int yr, input int bp, input int vw,
                      input int xo, input int yo, input int mem);
    @(negedge clk);
    req_xres = 16'(xr); req_yres = 16'(yr); req_bpp = 16'(bp);
    req_vwidth = 16'(vw); req_xoff = 16'(xo); req_yoff = 16'(yo);
    req_mem_bytes = 26'(mem);
    req_valid = 1'b1;
    q.push_back(model(xr, yr, bp, vw, xo, yo, mem));
    forever begin
      #1;
      if (req_ready) begin
        @(posedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  // result-side back-pressure pattern
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      res_ready = !bp_on || (cyc % 3 == 0);
    end
  end

  // monitor / scoreboard
  initial begin
    bit     stalled = 1'b0;
    longint s_start = 0, s_pitch = 0;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (stalled) begin
          // R10 hold under back-pressure
          check("R10 stall valid", longint'(res_valid), 1);
          check("R10 stall start", longint'(res_start), s_start);
          check("R10 stall pitch", longint'(res_pitch), s_pitch);
        end
        stalled = res_valid && !res_ready;
        s_start = longint'(res_start);
        s_pitch = longint'(res_pitch);
        if (req_valid && req_ready && res_valid && res_ready) overlap_seen = 1'b1;
        if (res_valid && res_ready) begin
          if (q.size() == 0) begin
            check("R11 unexpected result", 1, 0);
          end else begin
            exp_t e;
            e = q.pop_front();
            check("R1 xres", longint'(res_xres), e.xres);
            check("R2 yres", longint'(res_yres), e.yres);
            check("R3 vwidth", longint'(res_vwidth), e.vw);
            check("R4 R9 xoff", longint'(res_xoff), e.xoff);
            check("R4 R8 yoff", longint'(res_yoff), e.yoff);
            check("R5 R6 R7 pitch", longint'(res_pitch), e.pitch);
            check("R5 R6 R8 R9 start", longint'(res_start), e.start);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    check("R10 reset res_valid", longint'(res_valid), 0);
    check("R10 reset req_ready", longint'(req_ready), 1);

    // plain packed 8 bpp
    send(640, 480, 8, 0, 0, 0, 16777216);
    // R1 zero after masking, R2 zero height, 16 bpp
    send(5, 0, 16, 0, 0, 0, 16777216);
    // R2 R3 R4 upper clamps at 32 bpp with R8 fallback
    send(1023, 2000, 32, 3000, 5000, 2000, 16777216);
    // R5 planar
    send(800, 600, 4, 1024, 64, 10, 16777216);
    // R6 24 and 15 bpp
    send(1024, 768, 24, 1200, 7, 3, 16777216);
    send(1024, 768, 15, 1100, 9, 5, 16777216);
    // R7 unsupported depth
    send(320, 240, 7, 400, 10, 2, 16777216);
    // R3 floor wins over ceiling
    send(4000, 100, 8, 100, 0, 0, 16777216);

    bp_on = 1'b1;
    // R8 vertical pan dropped only
    send(320, 200, 8, 320, 100, 50, 70000);
    // R9 both pans dropped
    send(320, 200, 8, 320, 100, 50, 64000);
    // R9 planar: span alone too big
    send(1920, 1600, 4, 1920, 1920, 1600, 100000);
    // exact fit boundary R8
    send(320, 200, 8, 320, 0, 1, 64320);
    send(320, 200, 8, 320, 0, 1, 64319);
    bp_on = 1'b0;
    send(1280, 1024, 16, 1280, 16, 8, 4194304);

    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    // R11 accept in the same cycle a result leaves
    check("R11 overlap seen", longint'(overlap_seen), 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule